// File: doc/BRIEF.md
# PTP Frame Timestamp Capture Unit

This block sits beside the receive and transmit paths of an Ethernet MAC. On each start-of-frame strobe it sorts the frame into one of three groups: layer-2 precision-time frames (matched against a software-programmed Ethertype), UDP precision-time frames (matched by destination port) and all other traffic. When the frame carries an event message, the block latches a free-running 64-bit time counter. A receive capture also stores the frame's 80-bit source identity and 16-bit sequence ID. For every received frame it returns a packet-type code and a timestamp-taken flag, which the descriptor writer places into the status field.

On transmit, a capture happens only when the frame's descriptor command sets a timestamp request. The receive and transmit capture sets each have a valid flag. While a flag is set, its set is locked. Software unlocks it by reading the high timestamp word, after reading the low word. Reads use a small word-addressed port with combinational data and a read-enable strobe. The read-enable strobe carries the unlock side effect.

Top module: `ptp_stamp_unit`

## Requirements
- R1: After reset and after any later reset, `rx_ts_valid`, `tx_ts_valid`, `rx_stat_valid`, `rx_pkt_type` and `rx_ts_taken` are 0, and every readable word at addresses 0 to 7 reads 0.
- R2: One cycle after `rx_sof`, `rx_stat_valid` is 1 and `rx_pkt_type` is 4'hE when `rx_etype` equals `cfg_l2_etype`, else 4'h0. Frames identified only as UDP precision-time frames report 4'h0.
- R3: The 4'hE code is reported for every Ethertype match, whether or not a timestamp is captured for the frame.
- R4: A receive frame is an event frame when it is a layer-2 match with `rx_msg_type` 0 (sync) or 1 (delay request), or when `rx_is_udp` is 1 and `rx_udp_dport` is 319. An event frame arriving while the receive set is unlocked stores `time_now` as sampled in the `rx_sof` cycle. The next cycle shows `rx_ts_taken` = 1, and `rx_ts_valid` becomes 1.
- R5: Non-event frames are not timestamped. These include layer-2 matches with any other message type, UDP port 320 and all other traffic. For such frames `rx_ts_taken` is 0 and `rx_ts_valid` is left unchanged.
- R6: A receive capture also stores the source identity and sequence ID. Address 0 holds timestamp bits 31:0, address 1 holds bits 63:32, address 4 holds source bits 31:0 and address 5 holds source bits 63:32. Address 6 holds {sequence ID, source bits 79:64}. Address 7 holds {30'b0, tx_ts_valid, rx_ts_valid}.
- R7: While `rx_ts_valid` is 1, an event frame is not captured, `rx_ts_taken` stays 0 and the stored words are unchanged.
- R8: A read strobe at address 1 clears `rx_ts_valid` on the next edge. A read at address 0 leaves it set.
- R9: A transmit frame (`tx_sof`) is captured only when `tx_ts_req` is 1 and `tx_ts_valid` is 0. The capture stores `time_now` at addresses 2 (low) and 3 (high) and sets `tx_ts_valid`. A read strobe at address 3 clears the flag.
- R10: If an unlocking read and an event frame fall in the same cycle, the lock state before the edge decides the outcome. A locked set clears and does not capture (taken 0). An unlocked set captures, and the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low MAC reset |
| time_now | input | 64 | Free-running time counter value |
| cfg_l2_etype | input | 16 | Ethertype that marks layer-2 precision-time frames |
| rx_sof | input | 1 | Receive start-of-frame strobe; fields below valid with it |
| rx_etype | input | 16 | Parsed Ethertype |
| rx_is_udp | input | 1 | Frame parsed as UDP over IP |
| rx_udp_dport | input | 16 | UDP destination port |
| rx_msg_type | input | 4 | Precision-time message type |
| rx_src_id | input | 80 | Source port identity |
| rx_seq_id | input | 16 | Sequence ID |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_ts_req | input | 1 | Per-frame timestamp request from the descriptor command |
| rd_en | input | 1 | Read strobe (carries unlock side effect) |
| rd_addr | input | 3 | Read word address |
| rd_data | output | 32 | Read data for `rd_addr` |
| rx_stat_valid | output | 1 | Status below is for the frame strobed last cycle |
| rx_pkt_type | output | 4 | Packet-type code for descriptor status |
| rx_ts_taken | output | 1 | Timestamp-taken flag for descriptor status |
| rx_ts_valid | output | 1 | Receive capture set holds a value (locked) |
| tx_ts_valid | output | 1 | Transmit capture set holds a value (locked) |

## Verification
A software read of the receive high word can land in the same cycle as a new event frame's start strobe. This is the one place where the unlock path and the capture path meet. The bench drives both strobes on the same falling edge twice, once with the set locked and once with it unlocked. It then checks `rx_ts_taken` one cycle later, the valid flag, and the low timestamp word, which must hold the old value in the first case and the new value in the second.

// File: rtl/ptp_stamp_unit.sv
module ptp_stamp_unit #(
  parameter logic [15:0] EVENT_PORT = 16'd319,
  parameter logic [3:0]  L2_CODE    = 4'hE,
  parameter logic [3:0]  MSG_SYNC   = 4'd0,
  parameter logic [3:0]  MSG_DREQ   = 4'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] time_now,
  input  logic [15:0] cfg_l2_etype,
  input  logic        rx_sof,
  input  logic [15:0] rx_etype,
  input  logic        rx_is_udp,
  input  logic [15:0] rx_udp_dport,
  input  logic [3:0]  rx_msg_type,
  input  logic [79:0] rx_src_id,
  input  logic [15:0] rx_seq_id,
  input  logic        tx_sof,
  input  logic        tx_ts_req,
  input  logic        rd_en,
  input  logic [2:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        rx_stat_valid,
  output logic [3:0]  rx_pkt_type,
  output logic        rx_ts_taken,
  output logic        rx_ts_valid,
  output logic        tx_ts_valid
);

  logic [63:0] rx_ts_q, tx_ts_q;
  logic [79:0] src_q;
  logic [15:0] seq_q;

  wire rx_l2    = rx_etype == cfg_l2_etype;
  wire rx_l2_ev = rx_l2 && (rx_msg_type == MSG_SYNC || rx_msg_type == MSG_DREQ);
  wire rx_udp_ev = rx_is_udp && rx_udp_dport == EVENT_PORT;
  wire rx_hit   = rx_sof && (rx_l2_ev || rx_udp_ev) && !rx_ts_valid;
  wire rx_rel   = rd_en && rd_addr == 3'd1;
  wire tx_hit   = tx_sof && tx_ts_req && !tx_ts_valid;
  wire tx_rel   = rd_en && rd_addr == 3'd3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_stat_valid <= 1'b0;
      rx_pkt_type   <= 4'h0;
      rx_ts_taken   <= 1'b0;
      rx_ts_valid   <= 1'b0;
      tx_ts_valid   <= 1'b0;
      rx_ts_q       <= '0;
      tx_ts_q       <= '0;
      src_q         <= '0;
      seq_q         <= '0;
    end else begin
      rx_stat_valid <= rx_sof;
      rx_pkt_type   <= (rx_sof && rx_l2) ? L2_CODE : 4'h0;
      rx_ts_taken   <= rx_hit;
      if (rx_hit) begin
        rx_ts_q     <= time_now;
        src_q       <= rx_src_id;
        seq_q       <= rx_seq_id;
        rx_ts_valid <= 1'b1;
      end else if (rx_rel) begin
        rx_ts_valid <= 1'b0;
      end
      if (tx_hit) begin
        tx_ts_q     <= time_now;
        tx_ts_valid <= 1'b1;
      end else if (tx_rel) begin
        tx_ts_valid <= 1'b0;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = rx_ts_q[31:0];
      3'd1:    rd_data = rx_ts_q[63:32];
      3'd2:    rd_data = tx_ts_q[31:0];
      3'd3:    rd_data = tx_ts_q[63:32];
      3'd4:    rd_data = src_q[31:0];
      3'd5:    rd_data = src_q[63:32];
      3'd6:    rd_data = {seq_q, src_q[79:64]};
      default: rd_data = {30'b0, tx_ts_valid, rx_ts_valid};
    endcase
  end

  // R2
  pkt_type_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pkt_type != 4'h0) |-> rx_stat_valid);

  // R4
  taken_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ts_taken |-> (rx_ts_valid && rx_stat_valid));

  // R7
  locked_rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ts_valid && !rx_rel) |=> ($stable(rx_ts_q) && $stable(seq_q) && rx_ts_valid));

  // R8
  rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rel && !rx_sof) |=> !rx_ts_valid);

  // R9
  tx_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ts_valid && !(tx_sof && tx_ts_req)) |=> !tx_ts_valid);

  // R10
  locked_rel_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ts_valid && rx_rel) |=> (!rx_ts_taken && !rx_ts_valid));

endmodule

// File: tb/ptp_stamp_unit_tb.sv
module ptp_stamp_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] PTP_ET = 16'h88F7;
  localparam int NVEC = 9;
  // {etype, is_udp, dport, msg, exp_pkt, exp_taken}
  localparam logic [41:0] VEC [0:NVEC-1] = '{
    {16'h88F7, 1'b0, 16'd0,   4'd0, 4'hE, 1'b1},
    {16'h88F7, 1'b0, 16'd0,   4'd1, 4'hE, 1'b1},
    {16'h88F7, 1'b0, 16'd0,   4'd8, 4'hE, 1'b0},
    {16'h0800, 1'b1, 16'd319, 4'd0, 4'h0, 1'b1},
    {16'h0800, 1'b1, 16'd320, 4'd8, 4'h0, 1'b0},
    {16'h0800, 1'b1, 16'd53,  4'd0, 4'h0, 1'b0},
    {16'h86DD, 1'b0, 16'd0,   4'd0, 4'h0, 1'b0},
    {16'h88F7, 1'b0, 16'd0,   4'd9, 4'hE, 1'b0},
    {16'h0800, 1'b1, 16'd319, 4'd9, 4'h0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic [63:0] time_now = '0;
  logic [15:0] cfg_l2_etype = PTP_ET;
  logic rx_sof = 0, rx_is_udp = 0, tx_sof = 0, tx_ts_req = 0, rd_en = 0;
  logic [15:0] rx_etype = '0, rx_udp_dport = '0, rx_seq_id = '0;
  logic [3:0] rx_msg_type = '0;
  logic [79:0] rx_src_id = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic rx_stat_valid, rx_ts_taken, rx_ts_valid, tx_ts_valid;
  logic [3:0] rx_pkt_type;
  int checks = 0, fails = 0;
  logic [31:0] rv;
  logic [63:0] t_keep;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_stamp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .cfg_l2_etype(cfg_l2_etype),
    .rx_sof(rx_sof), .rx_etype(rx_etype), .rx_is_udp(rx_is_udp),
    .rx_udp_dport(rx_udp_dport), .rx_msg_type(rx_msg_type), .rx_src_id(rx_src_id),
    .rx_seq_id(rx_seq_id), .tx_sof(tx_sof), .tx_ts_req(tx_ts_req), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_stat_valid(rx_stat_valid),
    .rx_pkt_type(rx_pkt_type), .rx_ts_taken(rx_ts_taken), .rx_ts_valid(rx_ts_valid),
    .tx_ts_valid(tx_ts_valid));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; rd_en = 0; #1 d = rd_data;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; rd_en = 1; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_rx(input logic [15:0] et, input logic udp, input logic [15:0] pt,
                        input logic [3:0] mt, input logic [63:0] t, input logic [15:0] sq);
    rx_sof = 1; rx_etype = et; rx_is_udp = udp; rx_udp_dport = pt; rx_msg_type = mt;
    time_now = t; rx_seq_id = sq; rx_src_id = {sq, 64'hA5A5_0000_0000_0000 ^ t};
  endtask

  task automatic send_rx(input logic [15:0] et, input logic udp, input logic [15:0] pt,
                         input logic [3:0] mt, input logic [63:0] t, input logic [15:0] sq);
    @(negedge clk); set_rx(et, udp, pt, mt, t, sq);
    @(negedge clk); rx_sof = 0; time_now = ~t;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 flags", {rx_stat_valid, rx_pkt_type, rx_ts_taken, rx_ts_valid, tx_ts_valid}, 0);
    for (int a = 0; a < 8; a++) begin
      peek(a[2:0], rv); chk("R1 regs", rv, 0);
    end

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      logic [63:0] t;
      logic [41:0] v;
      v = VEC[i];
      t = {32'hBEE0_0000 + i, 32'h0001_0000 * (i + 3)};
      @(negedge clk); set_rx(v[41:26], v[25], v[24:9], v[8:5], t, 16'h0100 + i[15:0]);
      @(negedge clk); rx_sof = 0; time_now = ~t;
      chk("R2 stat_valid", rx_stat_valid, 1);
      chk("R2 R3 pkt_type", rx_pkt_type, v[4:1]);
      chk("R4 R5 taken", rx_ts_taken, v[0]);
      chk("R4 R5 valid", rx_ts_valid, v[0]);
      if (v[0]) begin
        rd(3'd4, rv); chk("R6 src lo", rv, t[31:0]);
        rd(3'd5, rv); chk("R6 src mid", rv, 32'hA5A5_0000 ^ t[63:32]);
        rd(3'd6, rv); chk("R6 seq", rv, {16'h0100 + i[15:0], 16'h0100 + i[15:0]});
        rd(3'd0, rv); chk("R4 ts lo", rv, t[31:0]);
        rd(3'd1, rv); chk("R4 ts hi", rv, t[63:32]);
        chk("R8 hi clears", rx_ts_valid, 0);
      end
    end

    // R7 lock, R3 code while locked, R8 low read keeps lock
    send_rx(PTP_ET, 0, 0, 0, 64'h1111_2222_3333_4444, 16'h0AAA);
    chk("R4 first", rx_ts_valid, 1);
    @(negedge clk); set_rx(PTP_ET, 0, 0, 1, 64'h9999_8888_7777_6666, 16'h0BBB);
    @(negedge clk); rx_sof = 0;
    chk("R7 no take", rx_ts_taken, 0);
    chk("R3 code locked", rx_pkt_type, 4'hE);
    rd(3'd0, rv); chk("R7 ts kept", rv, 32'h3333_4444);
    rd(3'd6, rv); chk("R7 seq kept", rv[31:16], 16'h0AAA);
    chk("R8 lo keeps", rx_ts_valid, 1);
    rd(3'd7, rv); chk("R6 flag word", rv, 32'h1);

    // R10 locked: unlock read and event frame together
    @(negedge clk); set_rx(PTP_ET, 0, 0, 0, 64'h5555_0000_5555_0000, 16'h0CCC);
    rd_en = 1; rd_addr = 3'd1;
    @(negedge clk); rx_sof = 0; rd_en = 0;
    chk("R10 locked taken", rx_ts_taken, 0);
    chk("R10 locked valid", rx_ts_valid, 0);
    peek(3'd0, rv); chk("R10 locked old ts", rv, 32'h3333_4444);

    // R10 unlocked: capture wins over read
    @(negedge clk); set_rx(16'h0800, 1, 319, 0, 64'h7777_0000_0000_1234, 16'h0DDD);
    rd_en = 1; rd_addr = 3'd1;
    @(negedge clk); rx_sof = 0; rd_en = 0;
    chk("R10 unlocked taken", rx_ts_taken, 1);
    chk("R10 unlocked valid", rx_ts_valid, 1);
    peek(3'd0, rv); chk("R10 new ts", rv, 32'h0000_1234);
    rd(3'd1, rv); chk("R8 clear", rx_ts_valid, 0);

    // R9 transmit
    @(negedge clk); tx_sof = 1; tx_ts_req = 0; time_now = 64'hDEAD_0000_0000_0001;
    @(negedge clk); tx_sof = 0;
    chk("R9 no req", tx_ts_valid, 0);
    @(negedge clk); tx_sof = 1; tx_ts_req = 1; time_now = 64'hCAFE_0001_F00D_0002;
    @(negedge clk); tx_sof = 1; time_now = 64'h0;
    @(negedge clk); tx_sof = 0; tx_ts_req = 0;
    chk("R9 valid", tx_ts_valid, 1);
    rd(3'd2, rv); chk("R9 tx lo", rv, 32'hF00D_0002);
    rd(3'd3, rv); chk("R9 tx hi", rv, 32'hCAFE_0001);
    chk("R9 release", tx_ts_valid, 0);
    chk("R9 rx untouched", rx_ts_valid, 0);

    // R1 later reset
    send_rx(PTP_ET, 0, 0, 0, 64'h4242_4242_4242_4242, 16'h0EEE);
    @(negedge clk); tx_sof = 1; tx_ts_req = 1;
    @(negedge clk); tx_sof = 0; tx_ts_req = 0; rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 re-reset flags", {rx_ts_valid, tx_ts_valid, rx_ts_taken}, 0);
    peek(3'd1, rv); chk("R1 re-reset ts", rv, 0);
    peek(3'd6, rv); chk("R1 re-reset seq", rv, 0);

    report();
  end
endmodule